// File: doc/BRIEF.md
# Multiplexed Address Bus Controller

This block connects a processor core to external memory over a narrow shared address bus. The core hands it one access at a time: a 16-bit address, a read or write flag and, for writes, a data byte. The controller splits the address into two halves and sends them over the same 8 pins. It sends the upper half first and raises a latch strobe so that an external latch captures that half. It then sends the lower half and drives the active-low read enable or write strobe. When the access finishes it raises a one-cycle done pulse. For reads, the data byte taken from the bidirectional data bus is presented to the core.

The controller remembers the upper address byte it last sent. If the next access falls in the same 256-byte page, the upper-byte phase is skipped and the access finishes one clock earlier. After reset the remembered byte is marked invalid.

Three configuration inputs change how the strobes are formed. A 2-bit shape setting selects a write pulse that lasts the whole cycle, only the low half of the clock or only the high half. Two gating bits hold the read enable or the write strobe inactive while the latch strobe is high. With all configuration inputs at zero, the write pulse lasts the whole cycle and no gating is applied.

Top module: `abus_mux_ctrl`

## Requirements
- R1: While reset is held, and until the first request after reset, rd_n and wr_n are 1, hi_strobe and done are 0, and the block does not drive bus_data.
- R2: The first access after reset always has an upper-byte phase. For exactly one cycle after the request is accepted, hi_strobe is 1 and bus_addr carries address bits 15:8. In the next cycle hi_strobe is 0 and bus_addr carries bits 7:0.
- R3: If an accepted address has the same bits 15:8 as the last upper byte sent, there is no upper-byte phase. In the first cycle after acceptance, bus_addr carries bits 7:0 and hi_strobe stays 0.
- R4: If an accepted address has different bits 15:8, the upper-byte phase is emitted again, and that byte becomes the new remembered value.
- R5: done is 1 for exactly one cycle: the cycle after the low-byte phase. In that cycle rd_n and wr_n are already inactive. For a read, rdata then holds the value that was on bus_data during the low-byte phase.
- R6: For a read, rd_n is 0 during both the upper-byte and the low-byte phases, and 1 at all other times. rd_n and wr_n are never 0 together.
- R7: When cfg_rd_gate is 1, rd_n is 1 while hi_strobe is 1. When cfg_rd_gate is 0, rd_n is 0 during the upper-byte phase of a read.
- R8: With cfg_wr_shape equal to 0 or 3, wr_n is 0 for the whole low-byte phase of a write.
- R9: With cfg_wr_shape equal to 1, wr_n is 0 only while clk is low during the low-byte phase of a write.
- R10: With cfg_wr_shape equal to 2, wr_n is 0 only while clk is high during the low-byte phase of a write.
- R11: wr_n is 1 whenever hi_strobe is 1, whatever the value of cfg_wr_gate.
- R12: During both phases of a write, the block drives the write byte onto bus_data. During reads it does not drive bus_data, so an external device can drive the byte to be read.
- R13: A request is accepted only when the controller is idle. A request that arrives during an access is ignored: it starts no access and does not change the remembered upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_shape | input | 2 | Write pulse shape: 0 full cycle, 1 clock-low half, 2 clock-high half, 3 as 0 |
| cfg_rd_gate | input | 1 | Hold the read enable inactive while hi_strobe is high |
| cfg_wr_gate | input | 1 | Hold the write strobe inactive while hi_strobe is high |
| req_valid | input | 1 | Start pulse for an access; sampled only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| bus_addr | output | 8 | Multiplexed address pins |
| hi_strobe | output | 1 | Latch strobe for the upper address byte |
| rd_n | output | 1 | Active-low read enable |
| wr_n | output | 1 | Active-low write strobe |
| bus_data | inout | 8 | Bidirectional data bus |

## Verification
The bench uses the default BUS_W of 8, which gives a 16-bit address split into two 8-bit halves. With this width the bench can pick addresses that share a page and addresses that differ only in the top bit or only in the lowest upper-address bit. These cases test the page comparison at both ends, and page 0x00 is reached directly. All four write-shape codes and both gating bits are set from the bench. So each strobe form is observed at the pins in both clock halves of the low-byte phase.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    WS_FULL  = 2'd0,
    WS_CLKLO = 2'd1,
    WS_CLKHI = 2'd2,
    WS_SPARE = 2'd3
  } wshape_e;

endpackage

// File: rtl/abus_rst_sync.sv
module abus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/abus_hicache.sv
module abus_hicache #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] hi_in,
  output logic             hit
);

  logic             valid_q;
  logic             valid_d;
  logic [BUS_W-1:0] page_q;
  logic [BUS_W-1:0] page_d;

  // next-state
  always_comb begin
    valid_d = valid_q;
    page_d  = page_q;
    if (load) begin
      valid_d = 1'b1;
      page_d  = hi_in;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load) begin
      valid_q <= valid_d;
      page_q  <= page_d;
    end
  end

  assign hit = valid_q && (page_q == hi_in);

endmodule

// File: rtl/abus_seq.sv
module abus_seq
  import abus_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              cache_hit,
  input  logic [BUS_W-1:0]  bus_rd,
  output logic              cache_load,
  output logic [BUS_W-1:0]  cache_page,
  output phase_e            phase,
  output logic              is_write,
  output logic [BUS_W-1:0]  addr_hi,
  output logic [BUS_W-1:0]  addr_lo,
  output logic [BUS_W-1:0]  wdata,
  output logic              done,
  output logic [BUS_W-1:0]  rdata
);

  phase_e              phase_q, phase_d;
  logic                accept;
  logic                finish;
  logic                write_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BUS_W-1:0]    wdata_q;
  logic                done_q;
  logic [BUS_W-1:0]    rdata_q;

  assign accept     = (phase_q == PH_IDLE) && req_valid;
  assign finish     = (phase_q == PH_LO);
  assign cache_page = req_addr[ADDR_W-1:BUS_W];
  assign cache_load = accept && !cache_hit;

  // next-state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_d = cache_hit ? PH_LO : PH_HI;
      PH_HI:   phase_d = PH_LO;
      PH_LO:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // state and completion registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read data capture, enabled at the end of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (finish && !write_q) begin
      rdata_q <= bus_rd;
    end
  end

  assign phase    = phase_q;
  assign is_write = write_q;
  assign addr_hi  = addr_q[ADDR_W-1:BUS_W];
  assign addr_lo  = addr_q[BUS_W-1:0];
  assign wdata    = wdata_q;
  assign done     = done_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/abus_strobe.sv
module abus_strobe
  import abus_pkg::*;
(
  input  logic       clk,
  input  phase_e     phase,
  input  logic       is_write,
  input  logic [1:0] cfg_wr_shape,
  input  logic       cfg_rd_gate,
  input  logic       cfg_wr_gate,
  output logic       hi_strobe,
  output logic       rd_n,
  output logic       wr_n,
  output logic       data_oe
);

  logic busy;
  logic hi_ph;
  logic rd_act;
  logic wr_win;
  logic wr_act;

  assign hi_ph  = (phase == PH_HI);
  assign busy   = (phase != PH_IDLE);
  assign rd_act = busy && !is_write && !(cfg_rd_gate && hi_ph);
  assign wr_win = (phase == PH_LO) && is_write;

  always_comb begin
    unique case (wshape_e'(cfg_wr_shape))
      WS_CLKLO: wr_act = wr_win && !clk;
      WS_CLKHI: wr_act = wr_win && clk;
      default:  wr_act = wr_win;
    endcase
    if (cfg_wr_gate && hi_ph) wr_act = 1'b0;
  end

  assign hi_strobe = hi_ph;
  assign rd_n      = !rd_act;
  assign wr_n      = !wr_act;
  assign data_oe   = busy && is_write;

endmodule

// File: rtl/abus_mux_ctrl.sv
module abus_mux_ctrl
  import abus_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_wr_shape,
  input  logic                 cfg_rd_gate,
  input  logic                 cfg_wr_gate,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2*BUS_W-1:0]   req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  output logic                 done,
  output logic [BUS_W-1:0]     rdata,
  output logic [BUS_W-1:0]     bus_addr,
  output logic                 hi_strobe,
  output logic                 rd_n,
  output logic                 wr_n,
  inout  wire  [BUS_W-1:0]     bus_data
);

  localparam int ADDR_W = 2 * BUS_W;

  logic             rst_core_n;
  logic             cache_hit;
  logic             cache_load;
  logic [BUS_W-1:0] cache_page;
  phase_e           phase;
  logic             is_write;
  logic [BUS_W-1:0] addr_hi;
  logic [BUS_W-1:0] addr_lo;
  logic [BUS_W-1:0] wdata;
  logic             data_oe;

  abus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  abus_hicache #(.BUS_W(BUS_W)) u_cache (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (cache_load),
    .hi_in (cache_page),
    .hit   (cache_hit)
  );

  abus_seq #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cache_hit  (cache_hit),
    .bus_rd     (bus_data),
    .cache_load (cache_load),
    .cache_page (cache_page),
    .phase      (phase),
    .is_write   (is_write),
    .addr_hi    (addr_hi),
    .addr_lo    (addr_lo),
    .wdata      (wdata),
    .done       (done),
    .rdata      (rdata)
  );

  abus_strobe u_strobe (
    .clk          (clk),
    .phase        (phase),
    .is_write     (is_write),
    .cfg_wr_shape (cfg_wr_shape),
    .cfg_rd_gate  (cfg_rd_gate),
    .cfg_wr_gate  (cfg_wr_gate),
    .hi_strobe    (hi_strobe),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .data_oe      (data_oe)
  );

  assign bus_addr = hi_strobe ? addr_hi : addr_lo;
  assign bus_data = data_oe ? wdata : 'z;

endmodule

// File: rtl/abus_mux_ctrl_chk.sv
module abus_mux_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rd_gate,
  input logic hi_strobe,
  input logic rd_n,
  input logic wr_n,
  input logic done
);

  AST_HI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_strobe |=> !hi_strobe); // R2

  AST_LO_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hi_strobe |=> !done); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && !hi_strobe)); // R5

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> wr_n); // R6

  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_gate && hi_strobe) |-> rd_n); // R7

  AST_WR_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_strobe |-> wr_n); // R11

endmodule

bind abus_mux_ctrl abus_mux_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_gate (cfg_rd_gate),
  .hi_strobe   (hi_strobe),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .done        (done)
);

// File: tb/abus_mux_ctrl_tb.sv
module abus_mux_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_wr_shape;
  logic        cfg_rd_gate;
  logic        cfg_wr_gate;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic [7:0]  bus_addr;
  logic        hi_strobe;
  logic        rd_n;
  logic        wr_n;
  wire  [7:0]  bus_data;
  logic        tb_oe;
  logic [7:0]  tb_drv;

  int n_chk;
  int n_fail;

  assign bus_data = tb_oe ? tb_drv : 8'hzz;

  abus_mux_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_shape(cfg_wr_shape),
    .cfg_rd_gate(cfg_rd_gate), .cfg_wr_gate(cfg_wr_gate),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .hi_strobe(hi_strobe), .rd_n(rd_n), .wr_n(wr_n), .bus_data(bus_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {write, expect upper phase, address, data}
  localparam logic [25:0] VEC [0:7] = '{
    {1'b0, 1'b1, 16'h1234, 8'hA5},
    {1'b0, 1'b0, 16'h1240, 8'h3C},
    {1'b1, 1'b0, 16'h12FF, 8'h77},
    {1'b1, 1'b1, 16'h9200, 8'h81},
    {1'b0, 1'b0, 16'h9201, 8'h00},
    {1'b0, 1'b1, 16'h0000, 8'hFF},
    {1'b1, 1'b0, 16'h0001, 8'h42},
    {1'b0, 1'b1, 16'h0134, 8'h99}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input bit exp_hi);
    bit lo_in_high;
    bit lo_in_low;
    lo_in_high = (cfg_wr_shape != 2'd1);
    lo_in_low  = (cfg_wr_shape != 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    tb_oe = !w; tb_drv = d;
    @(posedge clk); #1 req_valid = 1'b0;
    #4;
    if (exp_hi) begin
      chk(hi_strobe == 1'b1, "R2/R4 hi_strobe", 32'(hi_strobe), 1);
      chk(bus_addr == a[15:8], "R2 upper byte", 32'(bus_addr), 32'(a[15:8]));
      chk(rd_n == (w || cfg_rd_gate), "R7 rd_n in upper phase", 32'(rd_n),
          32'(w || cfg_rd_gate));
      chk(wr_n == 1'b1, "R11 wr_n in upper phase", 32'(wr_n), 1);
      if (w) chk(bus_data == d, "R12 drive in upper phase", 32'(bus_data), 32'(d));
      @(posedge clk); #5;
    end
    chk(hi_strobe == 1'b0, "R3 no hi_strobe in low phase", 32'(hi_strobe), 0);
    chk(bus_addr == a[7:0], "R2/R3 low byte", 32'(bus_addr), 32'(a[7:0]));
    chk(rd_n == w, "R6 rd_n in low phase", 32'(rd_n), 32'(w));
    if (w) begin
      chk(bus_data == d, "R12 write data", 32'(bus_data), 32'(d));
      chk(wr_n == !lo_in_high, "R8/R10 wr_n clk high", 32'(wr_n), 32'(!lo_in_high));
      #10;
      chk(wr_n == !lo_in_low, "R8/R9 wr_n clk low", 32'(wr_n), 32'(!lo_in_low));
    end else begin
      chk(wr_n == 1'b1, "R6 wr_n on read", 32'(wr_n), 1);
    end
    @(posedge clk); #5;
    chk(done == 1'b1, "R5 done", 32'(done), 1);
    chk(rd_n && wr_n, "R5 strobes idle at done", 32'({rd_n, wr_n}), 3);
    if (!w) chk(rdata == d, "R5/R12 read data", 32'(rdata), 32'(d));
    tb_oe = 1'b0;
    @(posedge clk); #5;
    chk(done == 1'b0, "R5 done single cycle", 32'(done), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_wr_shape = 2'd0; cfg_rd_gate = 1'b0; cfg_wr_gate = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    tb_oe = 1'b0; tb_drv = '0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    chk(rd_n && wr_n, "R1 strobes in reset", 32'({rd_n, wr_n}), 3);
    chk(!hi_strobe && !done, "R1 hi_strobe/done in reset", 32'({hi_strobe, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk(rd_n && wr_n && !hi_strobe && !done, "R1 idle after reset",
        32'({rd_n, wr_n, hi_strobe, done}), 32'b1100);

    // vector walk, baseline configuration (R2 R3 R4 R5 R6 R8 R12)
    for (int i = 0; i < 8; i++) begin
      access(VEC[i][25], VEC[i][23:8], VEC[i][7:0], VEC[i][24]);
    end

    // R9 clock-low write pulse; R10 clock-high pulse; R8 spare code
    cfg_wr_shape = 2'd1; access(1'b1, 16'h0150, 8'h5A, 1'b0);
    cfg_wr_shape = 2'd2; access(1'b1, 16'h4E00, 8'hA5, 1'b1);
    cfg_wr_shape = 2'd3; access(1'b1, 16'h4E10, 8'h0F, 1'b0);
    cfg_wr_shape = 2'd0;

    // R7 read gating; R11 write gating
    cfg_rd_gate = 1'b1; access(1'b0, 16'h7701, 8'hC3, 1'b1);
    cfg_rd_gate = 1'b0;
    cfg_wr_gate = 1'b1; access(1'b1, 16'h7802, 8'h11, 1'b1);
    cfg_wr_gate = 1'b0;

    // R13 request during an access is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3001; tb_oe = 1'b1; tb_drv = 8'h6B;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h8000; req_wdata = 8'hEE;
    @(posedge clk); #1 req_valid = 1'b0;
    #4;
    chk(bus_addr == 8'h01 && !hi_strobe, "R13 busy request ignored",
        32'({hi_strobe, bus_addr}), 32'h001);
    @(posedge clk); #5;
    chk(done && rdata == 8'h6B, "R13 original read completes", 32'(rdata), 32'h6B);
    tb_oe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #5;
      chk(rd_n && wr_n && !hi_strobe && !done, "R13 no extra access",
          32'({rd_n, wr_n, hi_strobe, done}), 32'b1100);
    end
    access(1'b0, 16'h8003, 8'h24, 1'b1);  // R13 page not taken by ignored request

    // R1 / R2 page memory forgotten after reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    access(1'b0, 16'h8004, 8'h3E, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule